// File: doc/BRIEF.md
# Pipelined Bus Transaction Attributor

This block is a passive observer for a split-transaction processor bus, on which the address tenure and the data tenure of a transfer are separate and can overlap. On every rising edge of the bus clock it samples the transfer-start strobe, the address-bus grant, the address, the transfer-code field, the data-bus grant, the data-valid strobe and the data bus. It drives nothing back onto the bus.

Each accepted transfer start places its address, its transaction kind (fetch, read or write, decoded from the transfer code) and its owner (local master or alternate master) into a small in-order queue. Each qualified data beat retires the oldest pending entry and produces one record that joins that address with the captured data. Records leave through a valid/ready port. A sticky error flag reports a transfer start lost to a full queue, or a record lost while the output port was stalled.

Ownership follows the arbitration arrangement, which is captured while reset is asserted. With the internal arbiter, a grant seen on the address-grant line in an earlier cycle than a transfer start marks that transfer as alternate-master. With an external arbiter the line is the local master's own grant, so the meaning is inverted.

Top module: `txn_attrib`

## Requirements
- R1: Inputs are sampled only on the rising clock edge. A data beat that pairs with a pending address makes `outValid` high in the cycle right after the edge that sampled the beat (one register stage).
- R2: Data beats retire pending addresses strictly in the order of their transfer starts, including when a second start arrives before the first data beat. A beat on the same edge as a start never pairs with that start.
- R3: In internal-arbiter mode, a transfer start (`tsN` low) preceded in an earlier cycle by `bgN` low is tagged alternate (`outAlt`=1). A start with no such grant is tagged local (`outAlt`=0).
- R4: A grant covers exactly one transfer start. The next start is alternate only if `bgN` is seen low again after the previous start. A grant on the same edge as the start neither counts for that start nor is kept.
- R5: A record carries the owner fixed at its transfer start, whatever grants are seen between that start and its data beat.
- R6: A data beat is an edge where `dbgN` and `dvalN` are both low. An edge with only one of them low, or a beat while no address is pending, produces no record and leaves the queue unchanged.
- R7: `outKind` decodes `tcIn` as sampled at the transfer start. Bit 1 clear gives write (2'b01). Bits 2 and 1 both set give fetch (2'b10). Bit 1 set with bit 2 clear gives read (2'b00). Bit 0 is ignored.
- R8: `cfgExtArb` is captured only while `rst` is high. When it is captured as 1, ownership is inverted: a start after a grant is local, and a start without one is alternate.
- R9: At most DEPTH (default 2) addresses are pending. A transfer start while the queue is full is dropped and sets `errSticky`, which stays set until reset.
- R10: A record stays valid and unchanged until `outReady` is high on a clock edge. A beat that completes while a record is held with `outReady` low still retires its queue entry, but its record is discarded and `errSticky` is set.
- R11: While reset is applied and after it is released, `outValid` and `errSticky` are 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfgExtArb | input | 1 | Arbitration arrangement, captured during reset (1 = external) |
| tsN | input | 1 | Transfer start, active low |
| bgN | input | 1 | Address-bus grant, active low |
| addrIn | input | ADDR_W | Address bus |
| tcIn | input | 3 | Transfer code |
| dbgN | input | 1 | Data-bus grant, active low |
| dvalN | input | 1 | Data-valid strobe, active low |
| dataIn | input | DATA_W | Data bus |
| outValid | output | 1 | Record available |
| outReady | input | 1 | Consumer accepts the record |
| outAddr | output | ADDR_W | Address of the completed transaction |
| outData | output | DATA_W | Captured data beat |
| outKind | output | 2 | 00 read, 01 write, 10 fetch |
| outAlt | output | 1 | 1 = alternate-master transaction |
| errSticky | output | 1 | Queue overflow or stalled-record loss seen |

## Verification
The case hardest to reach from the ports is a stalled output port that meets pipelined overlap. To reach it, the bench holds `outReady` low, issues two back-to-back transfer starts, and then issues two data beats. The first record must stay frozen while the second beat retires its entry, loses its record and raises the sticky flag. The bench also places a grant between an address tenure and its data tenure, to show that the owner is fixed at the start and that the late grant carries over to the next start.

// File: rtl/txn_attrib_pkg.sv
package txn_attrib_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_FETCH = 2'b10
  } kind_e;

  // strobes from control to datapath, one set per clock
  typedef struct packed {
    logic push;   // store sampled address into the write slot
    logic pop;    // retire the head slot
    logic emit;   // load the output record from the head slot
    logic alt;    // owner tag for the entry being pushed
  } strobe_t;

  function automatic kind_e classifyCode(input logic [2:0] tc);
    kind_e k;
    casez (tc)
      3'b?0?:  k = KIND_WRITE;
      3'b11?:  k = KIND_FETCH;
      default: k = KIND_READ;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/txn_attrib_ctrl.sv
module txn_attrib_ctrl
  import txn_attrib_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int PTR_W = 1,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgExtArb,
  input  logic             tsN,
  input  logic             bgN,
  input  logic             dbgN,
  input  logic             dvalN,
  input  logic             outReady,
  output strobe_t          strb,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             outValid,
  output logic             errSticky,
  output logic [CNT_W-1:0] pendCount
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic arbExt;
  logic grantSeen;
  logic startNow, beatNow, qFull, qEmpty, outBlocked;

  assign startNow   = !tsN;
  assign beatNow    = !dbgN && !dvalN;
  assign qFull      = (pendCount == FULL_CNT);
  assign qEmpty     = (pendCount == '0);
  assign outBlocked = outValid && !outReady;

  always_comb begin
    strb.push = startNow && !qFull;
    strb.pop  = beatNow && !qEmpty;
    strb.emit = strb.pop && !outBlocked;
    strb.alt  = arbExt ? !grantSeen : grantSeen;
  end

  // arbitration arrangement is frozen outside reset
  always_ff @(posedge clk) begin
    if (rst) arbExt <= cfgExtArb;
  end

  always_ff @(posedge clk) begin
    if (rst)           grantSeen <= 1'b0;
    else if (startNow) grantSeen <= 1'b0;
    else if (!bgN)     grantSeen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      pendCount <= '0;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= (rdPtr == LAST_SLOT) ? '0 : rdPtr + 1'b1;
      case ({strb.push, strb.pop})
        2'b10:   pendCount <= pendCount + 1'b1;
        2'b01:   pendCount <= pendCount - 1'b1;
        default: pendCount <= pendCount;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      if (strb.emit)    outValid <= 1'b1;
      else if (outReady) outValid <= 1'b0;
      if ((startNow && qFull) || (strb.pop && outBlocked)) errSticky <= 1'b1;
    end
  end

endmodule

// File: rtl/txn_attrib_dp.sv
module txn_attrib_dp
  import txn_attrib_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2,
  parameter int PTR_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [2:0]        tcIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  output logic [1:0]        outKind,
  output logic              outAlt
);

  logic [ADDR_W-1:0] slotAddr [DEPTH];
  kind_e             slotKind [DEPTH];
  logic              slotAlt  [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strb.push && wrPtr == PTR_W'(s)) begin
        slotAddr[s] <= addrIn;
        slotKind[s] <= classifyCode(tcIn);
        slotAlt[s]  <= strb.alt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outAddr <= '0;
      outData <= '0;
      outKind <= '0;
      outAlt  <= 1'b0;
    end else if (strb.emit) begin
      outAddr <= slotAddr[rdPtr];
      outData <= dataIn;
      outKind <= slotKind[rdPtr];
      outAlt  <= slotAlt[rdPtr];
    end
  end

endmodule

// File: rtl/txn_attrib.sv
module txn_attrib
  import txn_attrib_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgExtArb,
  input  logic              tsN,
  input  logic              bgN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [2:0]        tcIn,
  input  logic              dbgN,
  input  logic              dvalN,
  input  logic [DATA_W-1:0] dataIn,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  output logic [1:0]        outKind,
  output logic              outAlt,
  output logic              errSticky
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  strobe_t          strb;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] pendCount;

  txn_attrib_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst(rst), .cfgExtArb(cfgExtArb), .tsN(tsN), .bgN(bgN),
    .dbgN(dbgN), .dvalN(dvalN), .outReady(outReady), .strb(strb),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .outValid(outValid),
    .errSticky(errSticky), .pendCount(pendCount)
  );

  txn_attrib_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .addrIn(addrIn), .tcIn(tcIn), .dataIn(dataIn),
    .outAddr(outAddr), .outData(outData), .outKind(outKind), .outAlt(outAlt)
  );

endmodule

// File: rtl/txn_attrib_chk.sv
module txn_attrib_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              dbgN,
  input logic              dvalN,
  input logic              outValid,
  input logic              outReady,
  input logic [ADDR_W-1:0] outAddr,
  input logic [DATA_W-1:0] outData,
  input logic [1:0]        outKind,
  input logic              outAlt,
  input logic              errSticky,
  input logic [$clog2(DEPTH+1)-1:0] pendCount
);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outAddr) && $stable(outData)
                              && $stable(outKind) && $stable(outAlt));

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    errSticky |=> errSticky);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    pendCount <= ($clog2(DEPTH+1))'(DEPTH));

  p_beat_only_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> $past(!dbgN && !dvalN));

  p_reset_state_r11: assert property (@(posedge clk)
    $past(rst) |-> !outValid && !errSticky && pendCount == '0);

endmodule

bind txn_attrib txn_attrib_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/txn_attrib_tb_top.sv
module txn_attrib_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgExtArb = 1'b0;
  logic        tsN = 1'b1, bgN = 1'b1, dbgN = 1'b1, dvalN = 1'b1;
  logic [31:0] addrIn = '0, dataIn = '0;
  logic [2:0]  tcIn = '0;
  logic        outReady = 1'b1;
  logic        outValid, outAlt, errSticky;
  logic [31:0] outAddr, outData;
  logic [1:0]  outKind;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit modelExt = 0;

  typedef struct { logic [31:0] a; logic [1:0] k; logic alt; } pend_t;
  typedef struct { logic [31:0] a; logic [31:0] d; logic [1:0] k; logic alt; } rec_t;
  pend_t pendQ[$];
  rec_t  expQ[$];

  always #4 clk = ~clk;   // 125 MHz

  txn_attrib dut_i (
    .clk(clk), .rst(rst), .cfgExtArb(cfgExtArb), .tsN(tsN), .bgN(bgN),
    .addrIn(addrIn), .tcIn(tcIn), .dbgN(dbgN), .dvalN(dvalN), .dataIn(dataIn),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr),
    .outData(outData), .outKind(outKind), .outAlt(outAlt), .errSticky(errSticky)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expKind(input logic [2:0] tc);   // R7 decode
    if (!tc[1]) return 2'b01;
    if (tc[2])  return 2'b10;
    return 2'b00;
  endfunction

  task automatic drive(input logic ts, input logic bg, input logic dbg, input logic dv,
                       input logic [31:0] a, input logic [2:0] tc, input logic [31:0] d);
    @(negedge clk); #2;
    tsN = ts; bgN = bg; dbgN = dbg; dvalN = dv; addrIn = a; tcIn = tc; dataIn = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1, 1, 1, 1, 32'h0, 3'h0, 32'h0);
  endtask

  task automatic doStart(input logic [31:0] a, input logic [2:0] tc, input bit grantFirst, input bit accepted);
    pend_t p;
    if (grantFirst) drive(1, 0, 1, 1, 32'h0, 3'h0, 32'h0);
    drive(0, 1, 1, 1, a, tc, 32'h0);
    p.a = a; p.k = expKind(tc); p.alt = modelExt ? !grantFirst : grantFirst;
    if (accepted) pendQ.push_back(p);
  endtask

  task automatic doBeat(input logic [31:0] d, input bit keep);
    rec_t r;
    pend_t p;
    drive(1, 1, 0, 0, 32'h0, 3'h0, d);
    if (pendQ.size() > 0) begin
      p = pendQ.pop_front();
      r.a = p.a; r.d = d; r.k = p.k; r.alt = p.alt;
      if (keep) expQ.push_back(r);
    end
  endtask

  task automatic doReset(input logic ext);
    @(negedge clk); #2;
    rst = 1; cfgExtArb = ext;
    tsN = 1; bgN = 1; dbgN = 1; dvalN = 1;
    repeat (3) @(negedge clk);
    #2 rst = 0; cfgExtArb = ~ext;   // must have no effect after reset (R8)
    modelExt = ext;
    pendQ.delete(); expQ.delete();
  endtask

  // scoreboard monitor
  initial begin
    rec_t e;
    forever begin
      @(negedge clk);
      if (!rst && outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(0, "R2/R6 unexpected record", {32'h0, outAddr}, 64'h0);
        end else begin
          e = expQ.pop_front();
          check(outAddr == e.a, "R2 record address", outAddr, e.a);
          check(outData == e.d, "R1 record data", outData, e.d);
          check(outKind == e.k, "R7 record kind", outKind, e.k);
          check(outAlt == e.alt, "R3/R5/R8 record owner", outAlt, e.alt);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset(0);
    @(negedge clk);
    check(outValid == 0, "R11 valid after reset", outValid, 0);
    check(errSticky == 0, "R11 error after reset", errSticky, 0);

    // R1: record appears one cycle after the beat edge
    doStart(32'h1000_0000, 3'b010, 0, 1);
    doBeat(32'hAAAA_0001, 1);
    @(posedge clk); #1;
    check(outValid == 1, "R1 valid after beat edge", outValid, 1);
    idle(2);

    // R7 kinds
    doStart(32'h1000_0010, 3'b110, 0, 1); doBeat(32'hAAAA_0002, 1);
    doStart(32'h1000_0020, 3'b100, 0, 1); doBeat(32'hAAAA_0003, 1);
    doStart(32'h1000_0030, 3'b011, 0, 1); doBeat(32'hAAAA_0004, 1);
    doStart(32'h1000_0040, 3'b111, 0, 1); doBeat(32'hAAAA_0005, 1);
    idle(2);

    // R2 pipelined overlap
    doStart(32'h2000_0000, 3'b010, 0, 1);
    doStart(32'h2000_0004, 3'b000, 0, 1);
    doBeat(32'hBBBB_0001, 1);
    doBeat(32'hBBBB_0002, 1);
    idle(2);

    // R3/R4: grant covers one start only
    doStart(32'h3000_0000, 3'b010, 1, 1);
    doStart(32'h3000_0004, 3'b010, 0, 1);
    doBeat(32'hCCCC_0001, 1);
    doBeat(32'hCCCC_0002, 1);
    idle(2);

    // R4: grant on same edge as start does not count and is not kept
    drive(0, 0, 1, 1, 32'h3100_0000, 3'b010, 32'h0);
    begin pend_t p; p.a = 32'h3100_0000; p.k = 2'b00; p.alt = 0; pendQ.push_back(p); end
    doStart(32'h3100_0004, 3'b010, 0, 1);
    doBeat(32'hCCCC_0003, 1);
    doBeat(32'hCCCC_0004, 1);
    idle(2);

    // R5: grant between address and data does not change that record's owner
    doStart(32'h3200_0000, 3'b100, 0, 1);
    drive(1, 0, 1, 1, 32'h0, 3'h0, 32'h0);
    doBeat(32'hCCCC_0005, 1);
    // the late grant applies to the next start
    drive(0, 1, 1, 1, 32'h3200_0004, 3'b100, 32'h0);
    begin pend_t p; p.a = 32'h3200_0004; p.k = 2'b01; p.alt = 1; pendQ.push_back(p); end
    doBeat(32'hCCCC_0006, 1);
    idle(2);

    // R6: half beats ignored, empty-queue beat ignored
    doStart(32'h4000_0000, 3'b010, 0, 1);
    drive(1, 1, 0, 1, 32'h0, 3'h0, 32'hDEAD_0001);
    drive(1, 1, 1, 0, 32'h0, 3'h0, 32'hDEAD_0002);
    idle(1);
    check(outValid == 0, "R6 partial beat ignored", outValid, 0);
    doBeat(32'hDDDD_0001, 1);
    idle(2);
    drive(1, 1, 0, 0, 32'h0, 3'h0, 32'hDEAD_0003);
    idle(1);
    check(outValid == 0, "R6 beat on empty queue", outValid, 0);
    check(errSticky == 0, "R6 empty beat no error", errSticky, 0);
    idle(1);

    // R9: third start dropped while two are pending
    doStart(32'h5000_0000, 3'b010, 0, 1);
    doStart(32'h5000_0004, 3'b010, 0, 1);
    doStart(32'h5000_0008, 3'b010, 0, 0);
    idle(1);
    check(errSticky == 1, "R9 overflow flag", errSticky, 1);
    doBeat(32'hEEEE_0001, 1);
    doBeat(32'hEEEE_0002, 1);
    doBeat(32'hEEEE_0003, 1);
    idle(2);
    check(errSticky == 1, "R9 flag sticky", errSticky, 1);
    check(outValid == 0, "R9 dropped start gives no record", outValid, 0);

    // R11 reset clears flag
    doReset(0);
    @(negedge clk);
    check(errSticky == 0, "R11 flag cleared", errSticky, 0);

    // R10: held record with stall, second record lost
    @(negedge clk); #2 outReady = 0;
    doStart(32'h6000_0000, 3'b110, 0, 1);
    doStart(32'h6000_0004, 3'b010, 0, 1);
    doBeat(32'hFFFF_0001, 1);
    doBeat(32'hFFFF_0002, 0);
    idle(2);
    check(outValid == 1, "R10 record held", outValid, 1);
    check(outAddr == 32'h6000_0000, "R10 held address", outAddr, 32'h6000_0000);
    check(outData == 32'hFFFF_0001, "R10 held data", outData, 32'hFFFF_0001);
    check(errSticky == 1, "R10 lost record flag", errSticky, 1);
    @(negedge clk); #2 outReady = 1;
    idle(2);
    check(outValid == 0, "R10 cleared after accept", outValid, 0);

    // R8: external arbitration inverts ownership
    doReset(1);
    doStart(32'h7000_0000, 3'b010, 0, 1);
    doStart(32'h7000_0004, 3'b010, 1, 1);
    doBeat(32'h7777_0001, 1);
    doBeat(32'h7777_0002, 1);
    idle(3);

    check(expQ.size() == 0, "R2 all expected records seen", expQ.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule